// File: doc/BRIEF.md
# Interleaved DRAM Refresh Sequencer

This block chooses which bank and row of a 32-bank DRAM to refresh next. It issues each refresh as an activate strobe and, a fixed number of cycles later, a matching precharge strobe to the same bank. Banks are taken from a fixed interleaved order in which two refreshes in a row never hit neighbouring banks. A row counter moves on once per pass through that order.

In controller mode, every refresh tick from the memory controller starts one activate/precharge pair. A power-state input can ask for self-refresh, either through power-down or through nap with its enable bit set. The block enters self-refresh only at a pass boundary, so no row is skipped. While in self-refresh it paces refreshes with its own interval counter. When the request goes away, it finishes any open refresh and returns to controller mode at the start of the bank order.

The state machine has four states. `ST_CTRL_IDLE` waits for a tick. `ST_CTRL_HOLD` waits out tRAS after a controller activate. `ST_SR_IDLE` counts the self-refresh interval. `ST_SR_HOLD` waits out tRAS after a self-refresh activate. The transitions are:
- T_CTRL_ACT: `ST_CTRL_IDLE` to `ST_CTRL_HOLD`, on a tick.
- T_CTRL_PRE: `ST_CTRL_HOLD` to `ST_CTRL_IDLE`, when tRAS has elapsed.
- T_ENTER_SR: `ST_CTRL_IDLE` to `ST_SR_IDLE`, on a request while ready.
- T_SR_ACT: `ST_SR_IDLE` to `ST_SR_HOLD`, when the interval expires.
- T_SR_PRE: `ST_SR_HOLD` to `ST_SR_IDLE`, when tRAS has elapsed.
- T_SR_LEAVE: `ST_SR_IDLE` to `ST_CTRL_IDLE`, when the request drops.
- T_SR_PRE_LEAVE: `ST_SR_HOLD` to `ST_CTRL_IDLE`, when tRAS has elapsed and the request has dropped.

Top module: `rfsh_seq`

## Requirements
- R1: After reset the outputs are as follows. `cmd_valid_o` is 0 and `cmd_act_o` is 0. `cur_row_o` is 0. `cur_bank_o` is 13, the bank at position 0. `sleep_ready_o` is 1 and `self_ref_o` is 0.
- R2: The k-th activate since the sequence last restarted uses position p = k mod 32. With h = p div 16 and q = p mod 16, the bank is 16h plus a value that depends on q. That value is 13-2q for q<7, 2q-6 for 7≤q≤10, 2q-22 for 11≤q≤14, and 15 for q=15. Two consecutive activates never target banks that differ by 1.
- R3: `cmd_row_o` of an activate equals the row counter before that activate. The row counter, visible on `cur_row_o`, increments in the same cycle that an activate to bank 31 appears on the outputs. It wraps from 2^ROW_W-1 to 0.
- R4: Each activate is followed by exactly one precharge, with `cmd_valid_o`=1 and `cmd_act_o`=0. The precharge appears exactly TRAS_CYC cycles after its activate, with the same bank and row. No second activate appears while a row is open.
- R5: In controller mode with no pending sleep entry, a one-cycle tick is sampled by a clock edge. The activate appears on the outputs right after that edge. Ticks that arrive while a refresh is open are dropped.
- R6: A self-refresh request is `pwr_state_i`=2 (power-down), or `pwr_state_i`=1 (nap) with `nap_sr_en_i`=1. Encodings 0 and 3, and nap without the enable bit, never request it. A request is deferred until `sleep_ready_o` is 1, and ticks are still served while it waits. If a tick and an entry meet in the same cycle, entry wins and no activate is issued.
- R7: In self-refresh, the first activate appears SR_INTERVAL cycles after the entry edge, and further activates follow every SR_INTERVAL cycles. The bank order continues from position 0. Ticks are ignored.
- R8: When the request drops, the block returns to controller mode. If a self-refresh row is open, it first issues that row's precharge and leaves in the same cycle. On return, the position is 0, so `cur_bank_o` is 13.
- R9: `sleep_ready_o` is 1 exactly when the block is in controller mode with no open row and the next position is 0, meaning a full pass has completed. `self_ref_o` is 1 exactly while the block is in self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_tick_i | input | 1 | Controller refresh request, one cycle |
| pwr_state_i | input | 2 | Power state: 0 active, 1 nap, 2 power-down, 3 treated as active |
| nap_sr_en_i | input | 1 | Allows self-refresh when in nap |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_act_o | output | 1 | 1 for activate, 0 for precharge |
| cmd_bank_o | output | 5 | Bank of the command |
| cmd_row_o | output | ROW_W | Row of the command |
| cur_bank_o | output | 5 | Bank the next refresh will target |
| cur_row_o | output | ROW_W | Current row counter |
| sleep_ready_o | output | 1 | Pass complete, self-refresh entry allowed |
| self_ref_o | output | 1 | Self-refresh mode active |

## Verification
Two collisions are provoked, and both are judged at the command outputs.

The first is a refresh tick in the same cycle as a ready self-refresh request. The bench raises both on one falling edge. After the next rising edge it expects `self_ref_o` high and no activate strobe. The first activate must then come SR_INTERVAL cycles later, and it must target bank 13.

The second is the request dropping while a self-refresh row is open. The bench expects the precharge exactly TRAS_CYC cycles after the activate. Mode exit must happen in that same cycle, and `cur_bank_o` must be back at 13.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int BANK_W  = 5;
    localparam int POS_W   = 5;
    localparam int NUM_POS = 1 << POS_W;

    typedef enum logic [1:0] {
        ST_CTRL_IDLE = 2'd0,
        ST_CTRL_HOLD = 2'd1,
        ST_SR_IDLE   = 2'd2,
        ST_SR_HOLD   = 2'd3
    } rfsh_state_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_NAP    = 2'd1,
        PWR_DOWN   = 2'd2,
        PWR_RSVD   = 2'd3
    } pwr_state_e;

    // Bank for an order position: odd banks falling, then even banks
    // rising, with the top bank of each half last.
    function automatic logic [BANK_W-1:0] order_bank(input logic [POS_W-1:0] pos);
        logic [3:0] q;
        logic [3:0] lo;
        q = pos[3:0];
        if (q == 4'd15)
            lo = 4'd15;
        else if (q < 4'd7)
            lo = 4'd13 - {q[2:0], 1'b0};
        else if (q < 4'd11)
            lo = {q[2:0], 1'b0} - 4'd6;
        else
            lo = {q[2:0], 1'b0} - 4'd6;
        return {pos[4], lo};
    endfunction

endpackage

// File: rtl/rfsh_order_lut.sv
module rfsh_order_lut
    import rfsh_pkg::*;
(
    input  logic [POS_W-1:0]  pos_i,
    output logic [BANK_W-1:0] bank_o
);

    logic [BANK_W-1:0] table_q [NUM_POS];

    for (genvar g = 0; g < NUM_POS; g++) begin : g_entry
        assign table_q[g] = order_bank(POS_W'(g));
    end

    assign bank_o = table_q[pos_i];

endmodule

// File: rtl/rfsh_down_timer.sv
module rfsh_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rfsh_addr_ctr.sv
module rfsh_addr_ctr
    import rfsh_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clear_i,
    output logic [POS_W-1:0] pos_o,
    output logic [ROW_W-1:0] row_o
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_POS - 1);

    logic [POS_W-1:0] pos_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            row_q <= '0;
        end else begin
            if (clear_i)
                pos_q <= '0;
            else if (step_i)
                pos_q <= pos_q + 1'b1;
            if (step_i && pos_q == POS_LAST)
                row_q <= row_q + 1'b1;
        end
    end

    assign pos_o = pos_q;
    assign row_o = row_q;

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int ROW_W       = 9,
    parameter int TRAS_CYC    = 4,
    parameter int SR_INTERVAL = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfsh_tick_i,
    input  logic [1:0]        pwr_state_i,
    input  logic              nap_sr_en_i,
    output logic              cmd_valid_o,
    output logic              cmd_act_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic [BANK_W-1:0] cur_bank_o,
    output logic [ROW_W-1:0]  cur_row_o,
    output logic              sleep_ready_o,
    output logic              self_ref_o
);

    localparam int RAS_W = $clog2(TRAS_CYC) + 1;
    localparam int SRT_W = $clog2(SR_INTERVAL) + 1;
    localparam logic [RAS_W-1:0]  RAS_LOAD  = RAS_W'(TRAS_CYC - 1);
    localparam logic [SRT_W-1:0]  SRT_LOAD  = SRT_W'(SR_INTERVAL - 1);
    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'((1 << BANK_W) - 1);

    rfsh_state_e state_q, state_nxt;

    logic             sr_req;
    logic             pass_done;
    logic             do_act, do_pre, enter_sr, leave_sr;
    logic             in_sr, in_hold;
    logic             ras_zero, srt_zero;
    logic [RAS_W-1:0] ras_cnt;
    logic [SRT_W-1:0] srt_cnt;
    logic [POS_W-1:0] pos;
    logic [ROW_W-1:0] row;
    logic [BANK_W-1:0] lut_bank;

    assign sr_req = (pwr_state_e'(pwr_state_i) == PWR_DOWN) ||
                    ((pwr_state_e'(pwr_state_i) == PWR_NAP) && nap_sr_en_i);
    assign pass_done = (pos == '0);
    assign in_sr   = (state_q == ST_SR_IDLE) || (state_q == ST_SR_HOLD);
    assign in_hold = (state_q == ST_CTRL_HOLD) || (state_q == ST_SR_HOLD);

    // Transition logic
    always_comb begin
        state_nxt = state_q;
        do_act    = 1'b0;
        do_pre    = 1'b0;
        enter_sr  = 1'b0;
        leave_sr  = 1'b0;
        unique case (state_q)
            ST_CTRL_IDLE: begin
                if (sr_req && pass_done) begin          // T_ENTER_SR
                    state_nxt = ST_SR_IDLE;
                    enter_sr  = 1'b1;
                end else if (rfsh_tick_i) begin         // T_CTRL_ACT
                    state_nxt = ST_CTRL_HOLD;
                    do_act    = 1'b1;
                end
            end
            ST_CTRL_HOLD: begin
                if (ras_zero) begin                     // T_CTRL_PRE
                    state_nxt = ST_CTRL_IDLE;
                    do_pre    = 1'b1;
                end
            end
            ST_SR_IDLE: begin
                if (!sr_req) begin                      // T_SR_LEAVE
                    state_nxt = ST_CTRL_IDLE;
                    leave_sr  = 1'b1;
                end else if (srt_zero) begin            // T_SR_ACT
                    state_nxt = ST_SR_HOLD;
                    do_act    = 1'b1;
                end
            end
            ST_SR_HOLD: begin
                if (ras_zero) begin
                    do_pre = 1'b1;
                    if (sr_req) begin                   // T_SR_PRE
                        state_nxt = ST_SR_IDLE;
                    end else begin                      // T_SR_PRE_LEAVE
                        state_nxt = ST_CTRL_IDLE;
                        leave_sr  = 1'b1;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_CTRL_IDLE;
        else
            state_q <= state_nxt;
    end

    rfsh_order_lut i_lut (
        .pos_i  (pos),
        .bank_o (lut_bank)
    );

    rfsh_addr_ctr #(.ROW_W(ROW_W)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (do_act),
        .clear_i (leave_sr),
        .pos_o   (pos),
        .row_o   (row)
    );

    rfsh_down_timer #(.W(RAS_W)) i_ras (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (do_act),
        .load_val_i (RAS_LOAD),
        .dec_i      (in_hold),
        .cnt_o      (ras_cnt),
        .zero_o     (ras_zero)
    );

    rfsh_down_timer #(.W(SRT_W)) i_srt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (enter_sr || (in_sr && srt_zero)),
        .load_val_i (SRT_LOAD),
        .dec_i      (in_sr),
        .cnt_o      (srt_cnt),
        .zero_o     (srt_zero)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_o <= 1'b0;
            cmd_act_o   <= 1'b0;
            cmd_bank_o  <= '0;
            cmd_row_o   <= '0;
        end else begin
            cmd_valid_o <= do_act || do_pre;
            if (do_act) begin
                cmd_act_o  <= 1'b1;
                cmd_bank_o <= lut_bank;
                cmd_row_o  <= row;
            end else if (do_pre) begin
                cmd_act_o  <= 1'b0;
            end
        end
    end

    assign cur_bank_o    = lut_bank;
    assign cur_row_o     = row;
    assign sleep_ready_o = (state_q == ST_CTRL_IDLE) && pass_done;
    assign self_ref_o    = in_sr;

    // Checker state built from the outputs
    logic              ck_open;
    logic [15:0]       ck_gap;
    logic [BANK_W-1:0] ck_prev_bank;
    logic              ck_prev_ok;
    logic              ck_sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_open      <= 1'b0;
            ck_gap       <= '0;
            ck_prev_bank <= '0;
            ck_prev_ok   <= 1'b0;
            ck_sr_q      <= 1'b0;
        end else begin
            ck_sr_q <= self_ref_o;
            if (cmd_valid_o && cmd_act_o) begin
                ck_open      <= 1'b1;
                ck_gap       <= 16'd1;
                ck_prev_bank <= cmd_bank_o;
                ck_prev_ok   <= 1'b1;
            end else begin
                if (cmd_valid_o)
                    ck_open <= 1'b0;
                if (ck_open && ck_gap != 16'hffff)
                    ck_gap <= ck_gap + 1'b1;
                if (ck_sr_q && !self_ref_o)
                    ck_prev_ok <= 1'b0;
            end
        end
    end

    AST_ONE_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_act_o) |-> !ck_open);                             // R4
    AST_PRE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_act_o) |-> (ck_open && ck_gap == 16'(TRAS_CYC))); // R4
    AST_NOT_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_act_o && ck_prev_ok) |->
        (cmd_bank_o != ck_prev_bank + 1'b1 && ck_prev_bank != cmd_bank_o + 1'b1)); // R2
    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_act_o) |->
        (cur_row_o == ((cmd_bank_o == BANK_LAST) ? ROW_W'(cmd_row_o + 1'b1) : cmd_row_o))); // R3
    AST_SR_ENTRY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_ref_o) |-> $past(sleep_ready_o));                          // R6
    AST_EXIT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_ref_o) |-> (cur_bank_o == order_bank('0)));                // R8

endmodule

// File: tb/test_rfsh_seq.sv
module test_rfsh_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 4;
    localparam int ROWS       = 1 << ROW_W;
    localparam int TRAS       = 3;
    localparam int SRI        = 12;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [1:0]       pwr = 2'd0;
    logic             nap_en = 1'b0;
    logic             cmd_valid_o, cmd_act_o, sleep_ready_o, self_ref_o;
    logic [4:0]       cmd_bank_o, cur_bank_o;
    logic [ROW_W-1:0] cmd_row_o, cur_row_o;

    int ntests = 0;
    int nfail  = 0;
    int exp_pos = 0;
    int exp_row = 0;
    int prev_bank = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsh_seq #(.ROW_W(ROW_W), .TRAS_CYC(TRAS), .SR_INTERVAL(SRI)) i_rfsh_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .rfsh_tick_i   (tick),
        .pwr_state_i   (pwr),
        .nap_sr_en_i   (nap_en),
        .cmd_valid_o   (cmd_valid_o),
        .cmd_act_o     (cmd_act_o),
        .cmd_bank_o    (cmd_bank_o),
        .cmd_row_o     (cmd_row_o),
        .cur_bank_o    (cur_bank_o),
        .cur_row_o     (cur_row_o),
        .sleep_ready_o (sleep_ready_o),
        .self_ref_o    (self_ref_o)
    );

    function automatic int exp_bank(input int p);
        int h = p / 16;
        int q = p % 16;
        int b;
        if (q == 15)      b = 15;
        else if (q < 7)   b = 13 - 2 * q;
        else if (q < 11)  b = 2 * q - 6;
        else              b = 2 * q - 22;
        return b + 16 * h;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic see_act(input string req);
        int b = exp_bank(exp_pos);
        chk(req, cmd_valid_o, 1, "activate strobe");
        chk(req, cmd_act_o, 1, "activate kind");
        chk("R2", cmd_bank_o, b, "activate bank");
        chk("R3", cmd_row_o, exp_row, "activate row");
        if (prev_bank >= 0)
            chk("R2", (b - prev_bank == 1 || prev_bank - b == 1) ? 1 : 0, 0, "adjacent banks");
        prev_bank = b;
        if (b == 31) exp_row = (exp_row + 1) % ROWS;
        exp_pos = (exp_pos + 1) % 32;
        chk("R3", cur_row_o, exp_row, "row counter");
    endtask

    task automatic see_pre(input string req);
        chk(req, cmd_valid_o, 1, "precharge strobe");
        chk(req, cmd_act_o, 0, "precharge kind");
        chk(req, cmd_bank_o, prev_bank, "precharge bank");
    endtask

    // One controller refresh; a second tick lands while the row is open.
    task automatic ctrl_refresh();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        see_act("R5");
        for (int k = 1; k <= TRAS; k++) begin
            @(negedge clk);
            tick = (k == 1);
            if (k < TRAS) chk("R5", cmd_valid_o, 0, "tick while open dropped");
            else          see_pre("R4");
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", cmd_valid_o, 0, "reset strobe");
        chk("R1", cmd_act_o, 0, "reset kind");
        chk("R1", cur_row_o, 0, "reset row");
        chk("R1", cur_bank_o, 13, "reset bank");
        chk("R1", sleep_ready_o, 1, "reset ready");
        chk("R1", self_ref_o, 0, "reset mode");

        for (int i = 0; i < 5; i++) ctrl_refresh();
        chk("R9", sleep_ready_o, 0, "ready mid pass");

        // Power-down request mid pass is deferred; ticks still served.
        @(negedge clk) pwr = 2'd2;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R6", self_ref_o, 0, "deferred entry");
        end
        ctrl_refresh();
        chk("R6", self_ref_o, 0, "deferred after refresh");
        pwr = 2'd0;

        while (exp_pos != 0) ctrl_refresh();
        @(negedge clk);
        chk("R9", sleep_ready_o, 1, "ready at pass end");
        chk("R3", cur_row_o, 1, "row after first pass");

        // Non-requesting encodings.
        pwr = 2'd1; nap_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6", self_ref_o, 0, "nap without enable");
        pwr = 2'd3; nap_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", self_ref_o, 0, "reserved encoding");

        // Tick and entry in the same cycle: entry wins.
        pwr = 2'd1; tick = 1'b1;
        for (int k = 0; k <= 3 * SRI + TRAS; k++) begin
            @(negedge clk);
            tick = (k == 5);
            if (k == 0) begin
                chk("R6", self_ref_o, 1, "entry on collision");
                chk("R6", cmd_valid_o, 0, "no activate on collision");
            end else if (k % SRI == 0) begin
                see_act("R7");
            end else if (k > SRI && (k - TRAS) % SRI == 0) begin
                see_pre("R4");
            end else begin
                chk("R7", cmd_valid_o, 0, "self-refresh quiet");
            end
            if (k == 3 * SRI) pwr = 2'd0;
            if (k > 3 * SRI && k < 3 * SRI + TRAS)
                chk("R8", self_ref_o, 1, "stay until precharge");
        end
        chk("R8", self_ref_o, 0, "left with precharge");
        chk("R8", cur_bank_o, 13, "restart at origin");
        exp_pos = 0;
        prev_bank = -1;

        // Sweep full passes until the row counter wraps back.
        for (int i = 0; i < 32 * ROWS; i++) ctrl_refresh();
        chk("R3", cur_row_o, 1, "row after wrap");

        // Leave from the interval-wait state after one refresh.
        @(negedge clk) pwr = 2'd2;
        for (int k = 0; k <= SRI + TRAS + 2; k++) begin
            @(negedge clk);
            if (k == SRI) see_act("R7");
            else if (k == SRI + TRAS) see_pre("R4");
            else chk("R7", cmd_valid_o, 0, "self-refresh quiet");
        end
        pwr = 2'd0;
        @(negedge clk);
        chk("R8", self_ref_o, 0, "left from wait");
        chk("R8", cmd_valid_o, 0, "no command on leave");
        chk("R8", cur_bank_o, 13, "origin after leave");
        chk("R9", sleep_ready_o, 1, "ready after leave");

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule